// File: doc/BRIEF.md
# Header-Synchronised Serial Result Receiver

This block sits on the host side of a link to a 16-bit sampling converter whose result comes back on a single serial data line without any returned clock. On a request it drives a convert strobe, waits out the converter's latency, and then emits a burst of serial clock pulses. The converter moves to its next bit on each falling edge of that clock. The round trip through board and pads adds a delay that is not known in advance. The receiver absorbs it by sampling the data line at three points per serial bit and locating the first 1 of the frame header.

The system clock runs at three times the serial clock rate. The incoming line passes through two synchroniser flops. The receiver then looks for the first system cycle in which the line reads 1. It takes the following cycle as the centre of each bit and samples every third cycle after that. The second header bit must read 0. The next sixteen bits, most significant first, form the result, which is passed on unchanged as a two's-complement word with a one-cycle valid strobe. The bit position is learned afresh on every conversion. If the header never shows up, or is malformed, the receiver raises a one-cycle error pulse and produces no word.

A mode input selects the frame layout. In the normal layout the frame is header 1, header 0, then 16 data bits (18 clock pulses). In the older layout an extra 0 comes first (19 clock pulses).

Top module: `hdrsync_rx`

## Requirements
- R1: While reset is held, cnvOut, sclkOut, rxValid and syncErr are low and rxWord is zero.
- R2: A convReq seen high at a clock edge while the block is idle drives cnvOut high for exactly CNV_HIGH cycles, starting with that edge.
- R3: The clock burst starts LATENCY cycles after cnvOut falls. sclkOut is high for one cycle and low for two, and it is never high while cnvOut is high. The burst has 18 pulses when legacyHdr is 0 and 19 when it is 1. legacyHdr is sampled only at the accepted request.
- R4: A convReq that arrives while a conversion is in progress is ignored. No second cnvOut pulse occurs and the running conversion delivers its word normally.
- R5: The frame on serData, in order of the falling sclkOut edges, is [0 when legacyHdr=1], 1, 0, then data bit 15 down to bit 0. rxWord equals those sixteen data bits with the first received bit at position 15.
- R6: rxValid is a single-cycle pulse. It rises exactly 55 clock edges after the edge at which serData first goes high. Counted from the accepting request edge, that is CNV_HIGH + LATENCY + 57 + 3·L + D edges, where L is legacyHdr and D is the line delay in system cycles.
- R7: The word is received correctly for any line delay from 0 to 8 system cycles, in both frame layouts.
- R8: Let n be the number of edges from the first rising edge of sclkOut to the edge at which serData first goes high. If syncLimit ≤ n + 3, or serData never rises, syncErr pulses for one cycle at edge number syncLimit counted from that first sclkOut rise, and rxValid stays low. Otherwise no error is raised.
- R9: If the header bit sampled after the leading 1 reads 1, syncErr pulses once, 8 edges after the edge at which serData first went high, and no rxValid follows.
- R10: The sampling position is re-learned on every conversion. Back-to-back conversions with different line delays each yield their correct word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, three times the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| convReq | input | 1 | Request a conversion (accepted only when idle) |
| legacyHdr | input | 1 | 1 selects the frame with the extra leading 0 |
| syncLimit | input | SYNC_W | Clocks allowed for header arrival after the burst starts |
| serData | input | 1 | Serial data line from the converter |
| cnvOut | output | 1 | Convert strobe to the converter |
| sclkOut | output | 1 | Serial clock burst to the converter |
| rxWord | output | DATA_W | Last received two's-complement result |
| rxValid | output | 1 | One-cycle strobe marking a new rxWord |
| syncErr | output | 1 | One-cycle pulse on header timeout or malformed header |

## Verification
Every result is due at a fixed edge after the accepting request edge. cnvOut stays high for CNV_HIGH samples. rxValid appears at edge CNV_HIGH + LATENCY + 57 + 3·L + D. A timeout error appears at edge CNV_HIGH + LATENCY + syncLimit + 1, and a malformed header error at edge CNV_HIGH + LATENCY + 10 + 3·L + D. The bench counts edges from the request and samples on the falling clock edge after each rising edge. It records the first cycle in which each output is seen and compares it with these sums. It also checks that nothing further appears in the rest of the window.

// File: rtl/hdrsync_rx_pkg.sv
package hdrsync_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_BURST = 2'd3
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic active;   // search / capture window open
    logic clear;    // one-cycle flush before a new burst
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic locked;   // header 1 has been found
    logic wordDone; // last data bit captured this cycle
    logic hdrBad;   // header bits did not read 1 then 0
  } dpStatus_t;

endpackage

// File: rtl/hdrsync_rx_ctrl.sv
module hdrsync_rx_ctrl
  import hdrsync_rx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CNV_HIGH = 2,
  parameter int LATENCY  = 8,
  parameter int SYNC_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convReq,
  input  logic              legacyHdr,
  input  logic [SYNC_W-1:0] syncLimit,
  input  dpStatus_t         dpStat,
  output ctrlStrobe_t       strobe,
  output logic              cnvOut,
  output logic              sclkOut,
  output logic              syncErr
);

  localparam int TMR_MAX     = (CNV_HIGH > LATENCY) ? CNV_HIGH : LATENCY;
  localparam int TMR_W       = $clog2(TMR_MAX + 1);
  localparam int BASE_PULSES = DATA_W + 2;
  localparam int PULSE_W     = $clog2(BASE_PULSES + 2);

  rxState_e          state;
  logic [TMR_W-1:0]  tmr;
  logic [1:0]        ph;
  logic [PULSE_W-1:0] issued;
  logic [PULSE_W-1:0] pulseTotal;
  logic [SYNC_W-1:0] searchCnt;
  logic              sclkQ;
  logic              errQ;
  logic              legacyQ;

  assign pulseTotal = PULSE_W'(BASE_PULSES) + PULSE_W'(legacyQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tmr       <= '0;
      ph        <= '0;
      issued    <= '0;
      searchCnt <= '0;
      sclkQ     <= 1'b0;
      errQ      <= 1'b0;
      legacyQ   <= 1'b0;
    end else begin
      errQ  <= 1'b0;
      sclkQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (convReq) begin
            state   <= ST_CONV;
            tmr     <= TMR_W'(CNV_HIGH - 1);
            legacyQ <= legacyHdr;
          end
        end
        ST_CONV: begin
          if (tmr == '0) begin
            state <= ST_WAIT;
            tmr   <= TMR_W'(LATENCY - 1);
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        ST_WAIT: begin
          if (tmr == '0) begin
            state     <= ST_BURST;
            ph        <= 2'd2;
            issued    <= '0;
            searchCnt <= '0;
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
        ST_BURST: begin
          ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
          if (ph == 2'd2 && issued < pulseTotal) begin
            sclkQ  <= 1'b1;
            issued <= issued + PULSE_W'(1);
          end
          if (dpStat.wordDone) begin
            state <= ST_IDLE;
          end else if (dpStat.hdrBad) begin
            state <= ST_IDLE;
            errQ  <= 1'b1;
          end else if (!dpStat.locked) begin
            if (searchCnt == syncLimit) begin
              state <= ST_IDLE;
              errQ  <= 1'b1;
            end else begin
              searchCnt <= searchCnt + SYNC_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cnvOut        = (state == ST_CONV);
  assign sclkOut       = sclkQ;
  assign syncErr       = errQ;
  assign strobe.active = (state == ST_BURST);
  assign strobe.clear  = (state == ST_WAIT) && (tmr == '0);

  // R3
  sclk_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclkQ |=> !sclkQ);

  // R3
  cnv_no_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnvOut |-> !sclkQ);

  // R4
  conv_from_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cnvOut) |-> $past(state == ST_IDLE));

endmodule

// File: rtl/hdrsync_rx_dp.sv
module hdrsync_rx_dp
  import hdrsync_rx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              serData,
  output dpStatus_t         dpStat,
  output logic [DATA_W-1:0] rxWord,
  output logic              rxValid
);

  localparam int LAST_IDX = DATA_W + 1;
  localparam int IDX_W    = $clog2(DATA_W + 3);

  logic              sync1, sync2;
  logic              seen;
  logic [1:0]        phCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] shiftQ;
  logic [DATA_W-1:0] wordQ;
  logic              validQ;
  logic              hdrBadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= serData;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen    <= 1'b0;
      phCnt   <= '0;
      bitIdx  <= '0;
      shiftQ  <= '0;
      wordQ   <= '0;
      validQ  <= 1'b0;
      hdrBadQ <= 1'b0;
    end else begin
      validQ  <= 1'b0;
      hdrBadQ <= 1'b0;
      if (strobe.clear) begin
        shiftQ <= '0;
      end
      if (!strobe.active) begin
        seen   <= 1'b0;
        phCnt  <= '0;
        bitIdx <= '0;
      end else if (!seen) begin
        if (sync2) begin
          seen   <= 1'b1;
          phCnt  <= 2'd2;
          bitIdx <= '0;
        end
      end else if (phCnt == 2'd2) begin
        phCnt  <= 2'd0;
        bitIdx <= bitIdx + IDX_W'(1);
        if (bitIdx == IDX_W'(0) && !sync2) hdrBadQ <= 1'b1;
        if (bitIdx == IDX_W'(1) && sync2)  hdrBadQ <= 1'b1;
        if (bitIdx >= IDX_W'(2)) begin
          shiftQ <= {shiftQ[DATA_W-2:0], sync2};
        end
        if (bitIdx == IDX_W'(LAST_IDX)) begin
          wordQ  <= {shiftQ[DATA_W-2:0], sync2};
          validQ <= 1'b1;
        end
      end else begin
        phCnt <= phCnt + 2'd1;
      end
    end
  end

  assign dpStat.locked   = seen;
  assign dpStat.wordDone = validQ;
  assign dpStat.hdrBad   = hdrBadQ;
  assign rxWord          = wordQ;
  assign rxValid         = validQ;

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    validQ |=> !validQ);

  // R5
  valid_after_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> $past(seen));

  // R9
  hdr_no_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrBadQ |-> !validQ);

endmodule

// File: rtl/hdrsync_rx.sv
module hdrsync_rx
  import hdrsync_rx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CNV_HIGH = 2,
  parameter int LATENCY  = 8,
  parameter int SYNC_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convReq,
  input  logic              legacyHdr,
  input  logic [SYNC_W-1:0] syncLimit,
  input  logic              serData,
  output logic              cnvOut,
  output logic              sclkOut,
  output logic [DATA_W-1:0] rxWord,
  output logic              rxValid,
  output logic              syncErr
);

  ctrlStrobe_t strobe;
  dpStatus_t   dpStat;

  hdrsync_rx_ctrl #(
    .DATA_W  (DATA_W),
    .CNV_HIGH(CNV_HIGH),
    .LATENCY (LATENCY),
    .SYNC_W  (SYNC_W)
  ) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .convReq  (convReq),
    .legacyHdr(legacyHdr),
    .syncLimit(syncLimit),
    .dpStat   (dpStat),
    .strobe   (strobe),
    .cnvOut   (cnvOut),
    .sclkOut  (sclkOut),
    .syncErr  (syncErr)
  );

  hdrsync_rx_dp #(
    .DATA_W(DATA_W)
  ) dpInst (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .serData(serData),
    .dpStat (dpStat),
    .rxWord (rxWord),
    .rxValid(rxValid)
  );

  // R8
  err_valid_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |-> !rxValid);

endmodule

// File: tb/hdrsync_rx_test.sv
`timescale 1ns/1ps
module hdrsync_rx_test;
  localparam int DATA_W   = 16;
  localparam int CNV_HIGH = 2;
  localparam int LATENCY  = 8;
  localparam int SYNC_W   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convReq = 1'b0;
  logic legacyHdr = 1'b0;
  logic [SYNC_W-1:0] syncLimit = '0;
  logic serData;
  logic cnvOut, sclkOut, rxValid, syncErr;
  logic [DATA_W-1:0] rxWord;

  always #2.5 clk = ~clk;

  hdrsync_rx #(
    .DATA_W(DATA_W), .CNV_HIGH(CNV_HIGH), .LATENCY(LATENCY), .SYNC_W(SYNC_W)
  ) uut (
    .clk(clk), .rstN(rstN), .convReq(convReq), .legacyHdr(legacyHdr),
    .syncLimit(syncLimit), .serData(serData), .cnvOut(cnvOut),
    .sclkOut(sclkOut), .rxWord(rxWord), .rxValid(rxValid), .syncErr(syncErr)
  );

  // converter and line model
  logic [0:18] frameBits = '0;
  int          frameLen = 0;
  int          fallCnt = 0;
  int          sclkPulses = 0;
  logic        convBit = 1'b0;
  logic [15:0] dl = '0;
  int          dlySel = 0;

  always @(posedge cnvOut) begin
    convBit = 1'b0;
    fallCnt = 0;
    sclkPulses = 0;
  end
  always @(posedge sclkOut) sclkPulses++;
  always @(negedge sclkOut) begin
    if (fallCnt < frameLen) convBit = frameBits[fallCnt];
    fallCnt++;
  end
  always @(posedge clk) dl <= {dl[14:0], convBit};
  assign serData = (dlySel == 0) ? convBit : dl[dlySel-1];

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runConv(input logic [15:0] word, input bit legacy, input int dly,
                         input bit hdrBadBit, input bit noOne, input int limit,
                         input bit extraReq, input string tag);
    int j1 = legacy ? 1 : 0;
    int validK = -1, errK = -1, vCnt = 0, eCnt = 0, cnvCnt = 0;
    int expValid, expErr, kind;
    logic [15:0] got = '0;
    frameBits = '0;
    frameBits[j1] = noOne ? 1'b0 : 1'b1;
    frameBits[j1+1] = hdrBadBit;
    for (int k = 0; k < 16; k++) frameBits[j1+2+k] = word[15-k];
    frameLen = 18 + j1;
    dlySel = dly;
    // kind: 0 word expected, 1 timeout, 2 malformed header
    if (noOne || limit <= 4 + 3*j1 + dly) kind = 1;
    else if (hdrBadBit) kind = 2;
    else kind = 0;
    expValid = CNV_HIGH + LATENCY + 57 + 3*j1 + dly;
    expErr = (kind == 1) ? CNV_HIGH + LATENCY + limit + 1
                         : CNV_HIGH + LATENCY + 10 + 3*j1 + dly;
    @(negedge clk);
    convReq = 1'b1; legacyHdr = legacy; syncLimit = limit[SYNC_W-1:0];
    for (int kk = 0; kk < 100; kk++) begin
      @(negedge clk);
      if (kk == 0) legacyHdr = ~legacy; // changing the mode later must not matter (R3)
      convReq = (extraReq && kk == 20);
      if (cnvOut) cnvCnt++;
      if (rxValid) begin vCnt++; if (validK < 0) begin validK = kk; got = rxWord; end end
      if (syncErr) begin eCnt++; if (errK < 0) errK = kk; end
    end
    check(cnvCnt == CNV_HIGH, {tag, " R2 cnvOut width"}, cnvCnt, CNV_HIGH);
    if (kind == 0) begin
      check(vCnt == 1, {tag, " R6 valid count"}, vCnt, 1);
      check(validK == expValid, {tag, " R6 valid cycle"}, validK, expValid);
      check(got == word, {tag, " R5 word"}, got, word);
      check(eCnt == 0, {tag, " R8 no error"}, eCnt, 0);
      check(sclkPulses == 18 + j1, {tag, " R3 pulse count"}, sclkPulses, 18 + j1);
    end else begin
      check(vCnt == 0, {tag, (kind == 1) ? " R8" : " R9", " no word"}, vCnt, 0);
      check(eCnt == 1, {tag, (kind == 1) ? " R8" : " R9", " error count"}, eCnt, 1);
      check(errK == expErr, {tag, (kind == 1) ? " R8" : " R9", " error cycle"}, errK, expErr);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cnvOut == 1'b0, "R1 cnvOut", cnvOut, 0);
    check(sclkOut == 1'b0, "R1 sclkOut", sclkOut, 0);
    check(rxValid == 1'b0, "R1 rxValid", rxValid, 0);
    check(syncErr == 1'b0, "R1 syncErr", syncErr, 0);
    check(rxWord == '0, "R1 rxWord", rxWord, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R7 sweep: both layouts, delays 0..8, several words
    for (int lg = 0; lg < 2; lg++)
      for (int d = 0; d <= 8; d++)
        for (int p = 0; p < 4; p++) begin
          logic [15:0] w;
          case (p)
            0: w = 16'h8000;
            1: w = 16'h7FFF;
            2: w = 16'hFFFF ^ 16'(d);
            default: w = 16'h5A3C + 16'(d * 16'h0421);
          endcase
          runConv(w, lg[0], d, 1'b0, 1'b0, 200, 1'b0, "R7");
        end

    // R5 walking one and walking zero
    for (int b = 0; b < 16; b++) begin
      runConv(16'(1 << b), b[0], 3, 1'b0, 1'b0, 200, 1'b0, "R5");
      runConv(~16'(1 << b), ~b[0], 5, 1'b0, 1'b0, 200, 1'b0, "R5");
    end

    // R10 back-to-back with changing delay
    runConv(16'h1234, 1'b0, 8, 1'b0, 1'b0, 200, 1'b0, "R10");
    runConv(16'hFEDC, 1'b0, 0, 1'b0, 1'b0, 200, 1'b0, "R10");
    runConv(16'h0F0F, 1'b1, 5, 1'b0, 1'b0, 200, 1'b0, "R10");

    // R4 extra request during a conversion
    runConv(16'hC001, 1'b0, 2, 1'b0, 1'b0, 200, 1'b1, "R4");
    runConv(16'h3FFE, 1'b1, 7, 1'b0, 1'b0, 200, 1'b1, "R4");

    // R8 timeout boundaries and a missing header
    runConv(16'hAAAA, 1'b0, 2, 1'b0, 1'b0, 6, 1'b0, "R8");
    runConv(16'hAAAA, 1'b0, 2, 1'b0, 1'b0, 7, 1'b0, "R8");
    runConv(16'h5555, 1'b1, 4, 1'b0, 1'b0, 11, 1'b0, "R8");
    runConv(16'h5555, 1'b1, 4, 1'b0, 1'b0, 12, 1'b0, "R8");
    runConv(16'h0000, 1'b0, 1, 1'b0, 1'b1, 40, 1'b0, "R8");

    // R9 malformed header
    runConv(16'h0000, 1'b0, 1, 1'b1, 1'b0, 200, 1'b0, "R9");
    runConv(16'h9999, 1'b1, 6, 1'b1, 1'b0, 200, 1'b0, "R9");
    runConv(16'h2468, 1'b0, 4, 1'b0, 1'b0, 200, 1'b0, "R9");

    finishRun();
  end

endmodule